// File: doc/BRIEF.md
# Speculative Target Request Front End

This block sits between a transaction source and a shared bus that has one request/grant pair per slave target. Working out which slave an address belongs to takes several cycles, and winning arbitration for that slave takes several more. Instead of running these two phases one after the other, the block guesses the target and raises the bus request for the guess at once, while an external decoder works on the address.

The guess is the target of the most recent transaction that proceeded, held in a register that starts at target 0. When the decode result arrives, it is compared with the guess. If they match, the transfer proceeds as soon as the grant is also held. If they differ, the block drops the wrong request, leaves all request lines low for one cycle, requests the decoded target, and proceeds once that grant arrives.

A single-cycle proceed pulse reports the decoded target. Two counters record correct and wrong guesses. A new request is accepted only while the block is idle.

Top module: `spec_req_front`

## Requirements
- R1: After reset, all request lines and the proceed pulse are low, the ready output is high, both counters read 0, and the prediction register holds target 0.
- R2: The cycle after a request is accepted (ready and valid both high at a clock edge), the decode-start output is high for one cycle with the accepted address on the decode address output, and the request line of the predicted target is high.
- R3: At most one request line is high in any cycle.
- R4: When the decoded target equals the prediction, the proceed pulse appears in the cycle after the first cycle in which the decode result and the grant are both present. With decode latency L and grant delay D, this is max(L,D)+2 cycles after the acceptance cycle.
- R5: When the decoded target differs from the prediction, the wrong request line falls the cycle after the decode result, all request lines stay low for one cycle, and the decoded target's line is then raised. Proceed follows the grant, L+D+4 cycles after the acceptance cycle.
- R6: A request line never passes directly from one target to another without a cycle with no line high.
- R7: Proceed is a one-cycle pulse, and the proceed target output carries the decoded target during that pulse.
- R8: The prediction register takes the target of each transaction that proceeds.
- R9: The hit counter increases by one for each correctly predicted transaction, and the mispredict counter increases by one for each wrong prediction. Both wrap at their width and are updated at the edge that ends the decision cycle.
- R10: Ready is low from the acceptance until the proceed pulse. Request valid and address are ignored while ready is low.
- R11: While a request line is high and neither a grant nor a decode result is present, the same request line stays high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transaction request valid |
| reqAddr | input | ADDR_W | Transaction address |
| reqReady | output | 1 | Block idle, request can be accepted |
| decStart | output | 1 | One-cycle pulse that launches the external decode |
| decAddr | output | ADDR_W | Captured address for the decoder |
| decodeDone | input | 1 | Decode result valid, one cycle |
| decodeTarget | input | TGT_W | Decoded target index |
| grantVec | input | NUM_TGT | Per-target grant from the arbiter |
| busReq | output | NUM_TGT | Per-target request to the arbiter |
| proceed | output | 1 | Transfer may proceed, one-cycle pulse |
| proceedTarget | output | TGT_W | Target of the proceeding transfer |
| hitCount | output | CNT_W | Count of correct predictions |
| missCount | output | CNT_W | Count of wrong predictions |

## Verification
The assertions assume three things about the inputs. The arbiter grants only a target whose request line is high. The decoder answers exactly once per decode-start pulse, after a fixed latency, and never while the block is idle. The decoded target is below NUM_TGT. The bench keeps to these assumptions with a decoder model built from a delay line of exactly L stages and an arbiter model that counts consecutive request cycles per target and grants only a raised line after a programmable delay. Stimulus sweeps every ordered pair of targets over grant delays shorter than, equal to and longer than the decode latency. Half of the transactions keep valid high with a different address while busy.

// File: rtl/spec_req_pkg.sv
package spec_req_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SPEC,
    ST_GAP,
    ST_FIX
  } fsmState_e;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PRED,
    SEL_DEC
  } reqSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    accept;
    logic    captureDec;
    logic    hit;
    logic    miss;
    logic    proceed;
    reqSel_e sel;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic predMatch;
    logic grantPred;
    logic grantDec;
  } dpStatus_t;

endpackage

// File: rtl/spec_req_ctrl.sv
module spec_req_ctrl
  import spec_req_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        decodeDone,
  input  dpStatus_t   status,
  output ctrlStrobe_t strb,
  output logic        reqReady
);

  fsmState_e state, nextState;
  logic decKnownQ, grantedQ;
  logic decNow, grantNow;

  assign decNow   = decKnownQ | decodeDone;
  assign grantNow = grantedQ | status.grantPred;

  always_comb begin
    strb.accept     = 1'b0;
    strb.captureDec = 1'b0;
    strb.hit        = 1'b0;
    strb.miss       = 1'b0;
    strb.proceed    = 1'b0;
    strb.sel        = SEL_NONE;
    nextState       = state;
    reqReady        = (state == ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.accept = 1'b1;
          nextState   = ST_SPEC;
        end
      end
      ST_SPEC: begin
        strb.sel        = SEL_PRED;
        strb.captureDec = decodeDone;
        if (decNow && !status.predMatch) begin
          strb.miss = 1'b1;
          nextState = ST_GAP;
        end else if (decNow && grantNow) begin
          strb.hit     = 1'b1;
          strb.proceed = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      ST_GAP: begin
        nextState = ST_FIX;
      end
      ST_FIX: begin
        strb.sel = SEL_DEC;
        if (status.grantDec) begin
          strb.proceed = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      decKnownQ <= 1'b0;
      grantedQ  <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.accept) begin
        decKnownQ <= 1'b0;
        grantedQ  <= 1'b0;
      end else if (state == ST_SPEC) begin
        if (decodeDone)       decKnownQ <= 1'b1;
        if (status.grantPred) grantedQ  <= 1'b1;
      end
    end
  end

  // R10: once a request is taken, the block stays busy for the next cycle
  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqReady && reqValid) |=> !reqReady);

endmodule

// File: rtl/spec_req_dp.sv
module spec_req_dp
  import spec_req_pkg::*;
#(
  parameter int NUM_TGT = 4,
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 16,
  localparam int TGT_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobe_t        strb,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               decodeDone,
  input  logic [TGT_W-1:0]   decodeTarget,
  input  logic [NUM_TGT-1:0] grantVec,
  output dpStatus_t          status,
  output logic               decStart,
  output logic [ADDR_W-1:0]  decAddr,
  output logic [NUM_TGT-1:0] busReq,
  output logic               proceed,
  output logic [TGT_W-1:0]   proceedTarget,
  output logic [CNT_W-1:0]   hitCount,
  output logic [CNT_W-1:0]   missCount
);

  logic [ADDR_W-1:0] addrQ;
  logic              decStartQ;
  logic [TGT_W-1:0]  predQ, decQ, curDecTgt, reqTgt, procTgtQ;
  logic              procQ;
  logic [CNT_W-1:0]  hitQ, missQ;

  assign curDecTgt = decodeDone ? decodeTarget : decQ;
  assign reqTgt    = (strb.sel == SEL_DEC) ? decQ : predQ;

  generate
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_req
      assign busReq[t] = (strb.sel != SEL_NONE) && (reqTgt == TGT_W'(t));
    end
  endgenerate

  assign status.predMatch = (curDecTgt == predQ);
  assign status.grantPred = grantVec[predQ];
  assign status.grantDec  = grantVec[decQ];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrQ     <= '0;
      decStartQ <= 1'b0;
      predQ     <= '0;
      decQ      <= '0;
      procQ     <= 1'b0;
      procTgtQ  <= '0;
      hitQ      <= '0;
      missQ     <= '0;
    end else begin
      decStartQ <= strb.accept;
      procQ     <= strb.proceed;
      if (strb.accept)     addrQ <= reqAddr;
      if (strb.captureDec) decQ  <= decodeTarget;
      if (strb.proceed) begin
        procTgtQ <= curDecTgt;
        predQ    <= curDecTgt;
      end
      if (strb.hit)  hitQ  <= hitQ + CNT_W'(1);
      if (strb.miss) missQ <= missQ + CNT_W'(1);
    end
  end

  assign decStart      = decStartQ;
  assign decAddr       = addrQ;
  assign proceed       = procQ;
  assign proceedTarget = procTgtQ;
  assign hitCount      = hitQ;
  assign missCount     = missQ;

  // R3: never more than one target requested
  assert_one_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busReq));

  // R6: no direct hop from one target's line to another's
  assert_no_direct_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|$past(busReq)) && (|busReq)) |-> (busReq == $past(busReq)));

  // R7: proceed lasts one cycle
  assert_proceed_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proceed |=> !proceed);

  // R9: hit count moves only with a proceed pulse
  assert_hit_with_proceed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hitCount != $past(hitCount)) |-> proceed);

  // R5/R9: mispredict count moves as the request lines are released
  assert_miss_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (missCount != $past(missCount)) |-> (busReq == '0));

  // R11: an ungranted request with no decode result is held
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((|busReq) && !(|(busReq & grantVec)) && !decodeDone) |=> (busReq == $past(busReq)));

endmodule

// File: rtl/spec_req_front.sv
module spec_req_front
  import spec_req_pkg::*;
#(
  parameter int NUM_TGT = 4,
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 16,
  localparam int TGT_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               reqReady,
  output logic               decStart,
  output logic [ADDR_W-1:0]  decAddr,
  input  logic               decodeDone,
  input  logic [TGT_W-1:0]   decodeTarget,
  input  logic [NUM_TGT-1:0] grantVec,
  output logic [NUM_TGT-1:0] busReq,
  output logic               proceed,
  output logic [TGT_W-1:0]   proceedTarget,
  output logic [CNT_W-1:0]   hitCount,
  output logic [CNT_W-1:0]   missCount
);

  ctrlStrobe_t strb;
  dpStatus_t   status;

  spec_req_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .decodeDone (decodeDone),
    .status     (status),
    .strb       (strb),
    .reqReady   (reqReady)
  );

  spec_req_dp #(
    .NUM_TGT (NUM_TGT),
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .strb          (strb),
    .reqAddr       (reqAddr),
    .decodeDone    (decodeDone),
    .decodeTarget  (decodeTarget),
    .grantVec      (grantVec),
    .status        (status),
    .decStart      (decStart),
    .decAddr       (decAddr),
    .busReq        (busReq),
    .proceed       (proceed),
    .proceedTarget (proceedTarget),
    .hitCount      (hitCount),
    .missCount     (missCount)
  );

endmodule

// File: tb/spec_req_front_bench.sv
module spec_req_front_bench;

  localparam int NUM_TGT = 4;
  localparam int ADDR_W  = 16;
  localparam int CNT_W   = 16;
  localparam int TGT_W   = 2;
  localparam int DEC_LAT = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               reqValid = 1'b0;
  logic [ADDR_W-1:0]  reqAddr = '0;
  logic               reqReady, decStart, decodeDone, proceed;
  logic [ADDR_W-1:0]  decAddr;
  logic [TGT_W-1:0]   decodeTarget, proceedTarget;
  logic [NUM_TGT-1:0] grantVec, busReq;
  logic [CNT_W-1:0]   hitCount, missCount;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  int grantDelay = 0;
  int predModel = 0;
  int expHit = 0;
  int expMiss = 0;

  always #5 clk = ~clk;

  spec_req_front #(.NUM_TGT(NUM_TGT), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_spec_req_front (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr), .reqReady(reqReady),
    .decStart(decStart), .decAddr(decAddr), .decodeDone(decodeDone),
    .decodeTarget(decodeTarget), .grantVec(grantVec), .busReq(busReq), .proceed(proceed),
    .proceedTarget(proceedTarget), .hitCount(hitCount), .missCount(missCount)
  );

  // decoder model: fixed latency delay line, target = top address bits
  logic [DEC_LAT-1:0] donePipe;
  logic [TGT_W-1:0]   tgtPipe [DEC_LAT];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      donePipe <= '0;
      for (int i = 0; i < DEC_LAT; i++) tgtPipe[i] <= '0;
    end else begin
      donePipe[0] <= decStart;
      tgtPipe[0]  <= decAddr[ADDR_W-1 -: TGT_W];
      for (int i = 1; i < DEC_LAT; i++) begin
        donePipe[i] <= donePipe[i-1];
        tgtPipe[i]  <= tgtPipe[i-1];
      end
    end
  end
  assign decodeDone   = donePipe[DEC_LAT-1];
  assign decodeTarget = tgtPipe[DEC_LAT-1];

  // arbiter model: grant a raised line after grantDelay held cycles
  int grantCnt [NUM_TGT];
  always_ff @(posedge clk) begin
    for (int t = 0; t < NUM_TGT; t++)
      grantCnt[t] <= (rst_n && busReq[t]) ? grantCnt[t] + 1 : 0;
  end
  always_comb begin
    for (int t = 0; t < NUM_TGT; t++)
      grantVec[t] = busReq[t] && (grantCnt[t] >= grantDelay);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runTxn(input int tgt, input int gd, input bit holdValid);
    logic [ADDR_W-1:0] addr;
    bit isHit, done;
    int expLat, n;
    addr = {tgt[TGT_W-1:0], 14'((tgt * 37 + gd * 11 + 5) & 16'h3fff)};
    grantDelay = gd;
    isHit  = (tgt == predModel);
    expLat = isHit ? ((DEC_LAT > gd ? DEC_LAT : gd) + 2) : (DEC_LAT + gd + 4);
    check(reqReady == 1'b1, "R10 ready when idle", int'(reqReady), 1);
    reqValid = 1'b1;
    reqAddr  = addr;
    n = 0;
    done = 0;
    while (!done && n < 64) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        check(decStart == 1'b1, "R2 decode start", int'(decStart), 1);
        check(decAddr == addr, "R2 decode address", int'(decAddr), int'(addr));
        check(reqReady == 1'b0, "R10 busy after accept", int'(reqReady), 0);
        if (holdValid) reqAddr = ~addr;  // R10: ignored while busy
        else reqValid = 1'b0;
      end
      if (proceed) begin
        done = 1;
        reqValid = 1'b0;
        check(n == expLat, isHit ? "R4 hit latency" : "R5 miss latency", n, expLat);
        check(int'(proceedTarget) == tgt, "R7 proceed target", int'(proceedTarget), tgt);
        if (isHit) expHit++; else expMiss++;
        check(int'(hitCount) == expHit, "R9 hit count", int'(hitCount), expHit);
        check(int'(missCount) == expMiss, "R9 miss count", int'(missCount), expMiss);
      end else if (isHit || n <= DEC_LAT + 1) begin
        // R2/R11: predicted line held until decision
        check(int'(busReq) == (1 << predModel), "R11 predicted request held",
              int'(busReq), 1 << predModel);
      end else if (n == DEC_LAT + 2) begin
        check(busReq == '0, "R5 release gap", int'(busReq), 0);
      end else begin
        check(int'(busReq) == (1 << tgt), "R5 decoded target request",
              int'(busReq), 1 << tgt);
      end
    end
    if (!done) check(1'b0, "R4 proceed never seen", n, expLat);
    @(negedge clk);
    check(proceed == 1'b0, "R7 single-cycle proceed", int'(proceed), 0);
    predModel = tgt;  // R8: checked at the next transaction's first cycle
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busReq == '0, "R1 no request", int'(busReq), 0);
    check(reqReady == 1'b1, "R1 ready", int'(reqReady), 1);
    check(proceed == 1'b0, "R1 no proceed", int'(proceed), 0);
    check(hitCount == '0, "R1 hit count", int'(hitCount), 0);
    check(missCount == '0, "R1 miss count", int'(missCount), 0);
    // first transaction to target 0 must hit (R1 reset prediction)
    runTxn(0, 1, 1'b0);
    for (int gd = 0; gd <= DEC_LAT + 2; gd++)
      for (int a = 0; a < NUM_TGT; a++)
        for (int b = 0; b < NUM_TGT; b++) begin
          runTxn(a, gd, (b % 2) == 1);
          runTxn(b, gd, (a % 2) == 0);
        end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule